// File: doc/BRIEF.md
# Virtqueue Descriptor Chain Walker

This block pulls the next pending request out of a split virtqueue that lives in word-addressed memory. One page number is written to it. From that number it derives three base addresses: the descriptor table, the available ring and the used ring. The used ring always begins on a fresh 4 KiB page.

On a get command the block performs these steps:
- It reads the producer index from the available ring and compares it with its own next-available index. If the two are equal, the queue is empty.
- If the queue is not empty, it fetches the head index from the ring slot.
- It then follows the linked descriptors, emitting one segment record per descriptor with the buffer address, its length and a direction bit.

A get may consume the entry or only peek at it. A skip command consumes an entry without touching the descriptors. A guard on the segment count stops a chain that loops back on itself.

Memory is reached through a single read port: a one-cycle request pulse carrying an 8-byte-aligned byte address, answered later by a valid strobe with a 64-bit little-endian word. Only one read is outstanding at a time. Moving the data itself is left to the surrounding logic.

Top module: `vq_chain_walker`

## Requirements
- R1: After a page number P (nonzero) is loaded, the block sets its bases as follows:
  - `desc_base` = P·4096.
  - `avail_base` = `desc_base` + 16·QSIZE.
  - `used_base` = (`avail_base` + 4 + 2·QSIZE) rounded up to the next multiple of 4096.
- R2: Loading page number 0 clears the page number, all three bases and the next-available index. Loading any page number clears the next-available index. All of these are zero after reset. A load while busy is ignored. A load wins over a command offered in the same cycle.
- R3: The 16-bit producer index sits at bits 31:16 of the word at `avail_base`. When it equals the next-available index, any command ends with `done_ok`=0, emits no segment and leaves the index unchanged.
- R4: The head index is the 16-bit entry at byte `avail_base`+4+2·(index mod QSIZE). It is reported on `head_idx`.
- R5: Descriptor i is located at byte `desc_base`+16·(i mod QSIZE):
  - Its first word is the buffer address.
  - In its second word, bits 31:0 are the length, 47:32 the flags and 63:48 the next index.
  - Flag bit 1 (value 2) makes the segment device-writable (`seg_in`=1); otherwise it is an out segment.
- R6: The walk follows the next index while flag bit 0 (value 1) is set and ends at the first descriptor where it is clear. `in_cnt` and `out_cnt` count the segments emitted.
- R7: When the segment total reaches MAX_SEGS and the last descriptor still has bit 0 set, the walk ends with `loop_abort`=1. A chain of exactly MAX_SEGS that ends normally leaves `loop_abort`=0.
- R8: A non-empty get with `cmd_remove`=1 advances the next-available index by one when it completes. With `cmd_remove`=0 the index is left as it was.
- R9: A skip on a non-empty queue advances the index by one with `done_ok`=1 and reads no descriptor.
- R10: A command is accepted only while `busy` is low. `busy` stays high until the cycle in which the one-cycle `done` pulse appears. Each memory request is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load page number |
| cfg_pfn | input | PFN_W | Queue page number |
| cmd_valid | input | 1 | Start a command |
| cmd_skip | input | 1 | 1 = skip, 0 = get |
| cmd_remove | input | 1 | Get consumes the entry |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Aligned byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| seg_valid | output | 1 | Segment record valid |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment length |
| seg_in | output | 1 | Segment is device-writable |
| done | output | 1 | Command finished (pulse) |
| done_ok | output | 1 | An entry was taken or peeked |
| loop_abort | output | 1 | Walk cut by the count guard |
| head_idx | output | 16 | Head descriptor index |
| in_cnt | output | CNT_W | In-segment count |
| out_cnt | output | CNT_W | Out-segment count |
| next_avail | output | 16 | Next-available index |
| pfn | output | PFN_W | Stored page number |
| desc_base | output | ADDR_W | Descriptor table base |
| avail_base | output | ADDR_W | Available ring base |
| used_base | output | ADDR_W | Used ring base |

## Verification
The bench memory answers every request one edge later, so a read costs two cycles. Counting from the accepting edge, `done` for an empty queue or a skip appears after edge 2. The first segment appears after edge 8, and each further descriptor adds 4 edges, with `done` sharing the edge of the last segment. The bench counts edges after each accept and, at every falling edge, compares `seg_valid`, `done`, `busy` and `next_avail` with a behavioural walk of its own memory. Segment fields, head, counts and abort are compared in the cycles where they are due.

// File: rtl/vq_walk_pkg.sv
package vq_walk_pkg;
  localparam int PAGE_SHIFT  = 12;
  localparam int DESC_BYTES  = 16;
  localparam int FLG_CHAIN   = 0;
  localparam int FLG_DEVWR   = 1;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_PROD,
    WS_SLOT,
    WS_DLO,
    WS_DHI
  } walk_state_e;
endpackage

// File: rtl/vq_ring_layout.sv
module vq_ring_layout
  import vq_walk_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int PFN_W     = 32,
  parameter int QSIZE_LG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PFN_W-1:0]  load_pfn,
  output logic [PFN_W-1:0]  pfn_q,
  output logic [ADDR_W-1:0] tbl_base,
  output logic [ADDR_W-1:0] prod_base,
  output logic [ADDR_W-1:0] cons_base
);
  localparam int QSIZE = 1 << QSIZE_LG2;
  localparam logic [ADDR_W-1:0] TBL_BYTES  = ADDR_W'(DESC_BYTES * QSIZE);
  localparam logic [ADDR_W-1:0] PROD_BYTES = ADDR_W'(4 + 2 * QSIZE);
  localparam logic [ADDR_W-1:0] PAGE_LOW   = ADDR_W'((1 << PAGE_SHIFT) - 1);

  logic [ADDR_W-1:0] t_n, p_n, p_end, c_n;

  always_comb begin
    t_n   = ADDR_W'(load_pfn) << PAGE_SHIFT;
    p_n   = t_n + TBL_BYTES;
    p_end = p_n + PROD_BYTES;
    c_n   = (p_end + PAGE_LOW) & ~PAGE_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst || (load && load_pfn == '0)) begin
      pfn_q     <= '0;
      tbl_base  <= '0;
      prod_base <= '0;
      cons_base <= '0;
    end else if (load) begin
      pfn_q     <= load_pfn;
      tbl_base  <= t_n;
      prod_base <= p_n;
      cons_base <= c_n;
    end
  end

  assert_layout_order_R1: assert property (@(posedge clk) disable iff (rst)
    (pfn_q != '0) |-> (prod_base > tbl_base && cons_base > prod_base &&
                       cons_base[PAGE_SHIFT-1:0] == '0));
endmodule

// File: rtl/vq_walk_fsm.sv
module vq_walk_fsm
  import vq_walk_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int QSIZE_LG2 = 3,
  parameter int MAX_SEGS  = 8,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_idx,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] prod_base,
  input  logic              start,
  input  logic              start_skip,
  input  logic              start_remove,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  output logic              sg_valid,
  output logic [63:0]       sg_addr,
  output logic [31:0]       sg_len,
  output logic              sg_in,
  output logic              fin,
  output logic              fin_ok,
  output logic              fin_abort,
  output logic [15:0]       head,
  output logic [CNT_W-1:0]  n_in,
  output logic [CNT_W-1:0]  n_out,
  output logic [15:0]       avail_ptr
);
  walk_state_e       st;
  logic              skip_q, remove_q;
  logic [1:0]        half_q;
  logic [63:0]       lo_q;
  logic [ADDR_W-1:0] slot_byte;
  logic [CNT_W:0]    tot_next;
  logic [15:0]       prod_idx, slot_val, link;
  logic              chain, devwr;

  function automatic logic [ADDR_W-1:0] desc_word(input logic [15:0] idx);
    return tbl_base + (ADDR_W'(idx[QSIZE_LG2-1:0]) << 4);
  endfunction

  always_comb begin
    slot_byte = prod_base + ADDR_W'(4) + (ADDR_W'(avail_ptr[QSIZE_LG2-1:0]) << 1);
    tot_next  = {1'b0, n_in} + {1'b0, n_out} + (CNT_W+1)'(1);
    prod_idx  = rd_data[31:16];
    slot_val  = rd_data[{half_q, 4'b0000} +: 16];
    link      = rd_data[63:48];
    chain     = rd_data[32 + FLG_CHAIN];
    devwr     = rd_data[32 + FLG_DEVWR];
    busy      = (st != WS_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= WS_IDLE; skip_q <= 1'b0; remove_q <= 1'b0; half_q <= '0; lo_q <= '0;
      rd_req <= 1'b0; rd_addr <= '0; sg_valid <= 1'b0; sg_addr <= '0; sg_len <= '0;
      sg_in <= 1'b0; fin <= 1'b0; fin_ok <= 1'b0; fin_abort <= 1'b0; head <= '0;
      n_in <= '0; n_out <= '0; avail_ptr <= '0;
    end else begin
      rd_req   <= 1'b0;
      sg_valid <= 1'b0;
      fin      <= 1'b0;
      if (clr_idx) avail_ptr <= '0;
      case (st)
        WS_IDLE: if (start) begin
          skip_q <= start_skip; remove_q <= start_remove;
          n_in <= '0; n_out <= '0; fin_ok <= 1'b0; fin_abort <= 1'b0; head <= '0;
          rd_req <= 1'b1; rd_addr <= {prod_base[ADDR_W-1:3], 3'b000};
          st <= WS_PROD;
        end
        WS_PROD: if (rd_valid) begin
          if (prod_idx == avail_ptr) begin
            fin <= 1'b1; fin_ok <= 1'b0; st <= WS_IDLE;
          end else if (skip_q) begin
            fin <= 1'b1; fin_ok <= 1'b1; avail_ptr <= avail_ptr + 16'd1; st <= WS_IDLE;
          end else begin
            rd_req <= 1'b1; rd_addr <= {slot_byte[ADDR_W-1:3], 3'b000};
            half_q <= slot_byte[2:1]; st <= WS_SLOT;
          end
        end
        WS_SLOT: if (rd_valid) begin
          head <= slot_val;
          rd_req <= 1'b1; rd_addr <= desc_word(slot_val); st <= WS_DLO;
        end
        WS_DLO: if (rd_valid) begin
          lo_q <= rd_data;
          rd_req <= 1'b1; rd_addr <= rd_addr + ADDR_W'(8); st <= WS_DHI;
        end
        WS_DHI: if (rd_valid) begin
          sg_valid <= 1'b1; sg_addr <= lo_q; sg_len <= rd_data[31:0]; sg_in <= devwr;
          if (devwr) n_in <= n_in + CNT_W'(1);
          else       n_out <= n_out + CNT_W'(1);
          if (!chain || tot_next >= (CNT_W+1)'(MAX_SEGS)) begin
            fin <= 1'b1; fin_ok <= 1'b1; fin_abort <= chain;
            if (remove_q) avail_ptr <= avail_ptr + 16'd1;
            st <= WS_IDLE;
          end else begin
            rd_req <= 1'b1; rd_addr <= desc_word(link); st <= WS_DLO;
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

  assert_idx_step_R8: assert property (@(posedge clk) disable iff (rst)
    (avail_ptr != $past(avail_ptr) && !$past(clr_idx)) |-> avail_ptr == $past(avail_ptr) + 16'd1);
  assert_empty_keeps_idx_R3: assert property (@(posedge clk) disable iff (rst)
    (fin && !fin_ok) |-> avail_ptr == $past(avail_ptr));
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, n_in} + {1'b0, n_out}) <= (CNT_W+1)'(MAX_SEGS));
  assert_abort_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fin_abort) |-> fin);
  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
endmodule

// File: rtl/vq_chain_walker.sv
module vq_chain_walker
  import vq_walk_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int PFN_W     = 32,
  parameter int QSIZE_LG2 = 3,
  parameter int MAX_SEGS  = 8,
  localparam int CNT_W    = $clog2(MAX_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [PFN_W-1:0]  cfg_pfn,
  input  logic              cmd_valid,
  input  logic              cmd_skip,
  input  logic              cmd_remove,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              seg_valid,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len,
  output logic              seg_in,
  output logic              done,
  output logic              done_ok,
  output logic              loop_abort,
  output logic [15:0]       head_idx,
  output logic [CNT_W-1:0]  in_cnt,
  output logic [CNT_W-1:0]  out_cnt,
  output logic [15:0]       next_avail,
  output logic [PFN_W-1:0]  pfn,
  output logic [ADDR_W-1:0] desc_base,
  output logic [ADDR_W-1:0] avail_base,
  output logic [ADDR_W-1:0] used_base
);
  logic cfg_take, cmd_take;
  assign cfg_take = cfg_we && !busy;
  assign cmd_take = cmd_valid && !cfg_we;

  vq_ring_layout #(.ADDR_W(ADDR_W), .PFN_W(PFN_W), .QSIZE_LG2(QSIZE_LG2)) u_layout (
    .clk(clk), .rst(rst), .load(cfg_take), .load_pfn(cfg_pfn),
    .pfn_q(pfn), .tbl_base(desc_base), .prod_base(avail_base), .cons_base(used_base)
  );

  vq_walk_fsm #(.ADDR_W(ADDR_W), .QSIZE_LG2(QSIZE_LG2), .MAX_SEGS(MAX_SEGS), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst(rst), .clr_idx(cfg_take),
    .tbl_base(desc_base), .prod_base(avail_base),
    .start(cmd_take), .start_skip(cmd_skip), .start_remove(cmd_remove),
    .busy(busy), .rd_req(mem_req), .rd_addr(mem_addr),
    .rd_valid(mem_rvalid), .rd_data(mem_rdata),
    .sg_valid(seg_valid), .sg_addr(seg_addr), .sg_len(seg_len), .sg_in(seg_in),
    .fin(done), .fin_ok(done_ok), .fin_abort(loop_abort), .head(head_idx),
    .n_in(in_cnt), .n_out(out_cnt), .avail_ptr(next_avail)
  );
endmodule

// File: tb/vq_chain_walker_test.sv
`timescale 1ns/1ps
module vq_chain_walker_test;
  localparam int AW = 48;
  localparam int PW = 32;
  localparam int QN = 8;
  localparam int MS = 8;
  localparam int CW = $clog2(MS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [PW-1:0] cfg_pfn = '0;
  logic cmd_valid = 1'b0, cmd_skip = 1'b0, cmd_remove = 1'b0;
  logic busy, mem_req, mem_rvalid, seg_valid, seg_in, done, done_ok, loop_abort;
  logic [AW-1:0] mem_addr, desc_base, avail_base, used_base;
  logic [63:0] mem_rdata, seg_addr;
  logic [31:0] seg_len;
  logic [15:0] head_idx, next_avail;
  logic [CW-1:0] in_cnt, out_cnt;
  logic [PW-1:0] pfn;

  logic [63:0] mem [0:2047];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  longint m_desc = 0, m_avail = 0;
  int m_idx = 0;

  always #2.5 clk = ~clk;

  vq_chain_walker #(.ADDR_W(AW), .PFN_W(PW), .QSIZE_LG2(3), .MAX_SEGS(MS)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pfn(cfg_pfn),
    .cmd_valid(cmd_valid), .cmd_skip(cmd_skip), .cmd_remove(cmd_remove),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len), .seg_in(seg_in),
    .done(done), .done_ok(done_ok), .loop_abort(loop_abort), .head_idx(head_idx),
    .in_cnt(in_cnt), .out_cnt(out_cnt), .next_avail(next_avail),
    .pfn(pfn), .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base)
  );

  always_ff @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[13:3]];
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint rd16(input longint a);
    logic [63:0] w;
    w = mem[int'((a >> 3) & 2047)];
    return longint'(w[16*int'((a >> 1) & 3) +: 16]);
  endfunction

  task automatic wr16(input longint a, input longint v);
    mem[int'((a >> 3) & 2047)][16*int'((a >> 1) & 3) +: 16] = 16'(v);
  endtask

  task automatic put_desc(input int i, input longint ad, input int ln, input int fl, input int nx);
    mem[int'(((m_desc + 16*i) >> 3) & 2047)]     = 64'(ad);
    mem[int'(((m_desc + 16*i) >> 3) & 2047) + 1] = {16'(nx), 16'(fl), 32'(ln)};
  endtask

  task automatic load_pfn(input longint p);
    longint d, a, u;
    @(negedge clk); cfg_we = 1'b1; cfg_pfn = PW'(p);
    @(negedge clk); cfg_we = 1'b0;
    d = p << 12; a = (p == 0) ? 0 : d + 16*QN;
    u = (p == 0) ? 0 : ((a + 4 + 2*QN + 4095) & ~longint'(4095));
    chk("R1", "desc_base", longint'(desc_base), d);
    chk("R1", "avail_base", longint'(avail_base), a);
    chk("R1", "used_base", longint'(used_base), u);
    chk("R2", "pfn", longint'(pfn), p);
    chk("R2", "index cleared", longint'(next_avail), 0);
    m_desc = d; m_avail = a; m_idx = 0;
  endtask

  // behavioural walk, then cycle-by-cycle comparison
  task automatic run_cmd(input bit skp, input bit rem);
    longint e_ad [0:15];
    longint e_ln [0:15];
    bit     e_in [0:15];
    int n = 0, ni = 0, no = 0, due, k = 0;
    bit empty, abrt = 0;
    longint hd = 0, cur, w1;
    empty = (rd16(m_avail + 2) == longint'(16'(m_idx)));
    if (!empty && !skp) begin
      hd = rd16(m_avail + 4 + 2*(m_idx % QN));
      cur = hd;
      forever begin
        longint da;
        da = m_desc + 16*(cur % QN);
        e_ad[n] = longint'(mem[int'((da >> 3) & 2047)]);
        w1 = longint'(mem[int'((da >> 3) & 2047) + 1]);
        e_ln[n] = w1 & 64'hFFFF_FFFF;
        e_in[n] = ((w1 >> 33) & 1) != 0;
        if (e_in[n]) ni++; else no++;
        n++;
        if (((w1 >> 32) & 1) == 0) break;
        if (n >= MS) begin abrt = 1; break; end
        cur = (w1 >> 48) & 16'hFFFF;
      end
    end
    due = (n == 0) ? 2 : 8 + 4*(n - 1);
    @(negedge clk); cmd_valid = 1'b1; cmd_skip = skp; cmd_remove = rem;
    @(posedge clk);
    @(negedge clk); cmd_valid = 1'b0;
    for (int r = 1; r <= due + 2; r++) begin
      bit seg_due;
      @(posedge clk); @(negedge clk);
      seg_due = (n > 0) && (r >= 8) && ((r - 8) % 4 == 0) && (k < n);
      chk("R10", "seg_valid timing", longint'(seg_valid), longint'(seg_due));
      if (seg_due) begin
        chk("R5", "seg_addr", longint'(seg_addr), e_ad[k]);
        chk("R5", "seg_len", longint'(seg_len), e_ln[k]);
        chk("R5", "seg_in", longint'(seg_in), longint'(e_in[k]));
        k++;
      end
      chk("R10", "done timing", longint'(done), longint'(r == due));
      chk("R10", "busy", longint'(busy), longint'(r < due));
      if (r == due) begin
        chk(skp ? "R9" : "R3", "done_ok", longint'(done_ok), longint'(!empty));
        if (!empty && !skp) begin
          chk("R4", "head_idx", longint'(head_idx), hd);
          chk("R6", "in_cnt", longint'(in_cnt), ni);
          chk("R6", "out_cnt", longint'(out_cnt), no);
          chk("R7", "loop_abort", longint'(loop_abort), longint'(abrt));
        end
        if (!empty && (skp || rem)) m_idx = (m_idx + 1) & 16'hFFFF;
      end
      chk("R8", "next_avail", longint'(next_avail), longint'(m_idx));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R2", "reset desc_base", longint'(desc_base), 0);
    chk("R2", "reset used_base", longint'(used_base), 0);
    chk("R2", "reset next_avail", longint'(next_avail), 0);
    chk("R10", "reset busy", longint'(busy), 0);
    chk("R10", "reset done", longint'(done), 0);

    load_pfn(1);
    run_cmd(0, 1);                       // R3 empty get
    wr16(m_avail + 2, 3);
    wr16(m_avail + 4, 2); wr16(m_avail + 6, 5); wr16(m_avail + 8, 7);
    put_desc(2, 64'hA000_0000_0001, 100, 1, 4);
    put_desc(4, 64'hB000_0000_0002, 200, 3, 6);
    put_desc(6, 64'hC000_0000_0003, 300, 2, 0);
    run_cmd(0, 0);                       // R8 peek keeps index
    run_cmd(0, 1);                       // R8 remove advances
    run_cmd(1, 0);                       // R9 skip
    put_desc(7, 64'h1234_5678, 40, 1, 13);  // R5 next 13 wraps to 5
    put_desc(5, 64'h9ABC_DEF0, 50, 0, 0);
    run_cmd(0, 1);
    run_cmd(1, 0);                       // R9 skip on empty
    wr16(m_avail + 2, 4); wr16(m_avail + 10, 1);
    put_desc(1, 64'h5555, 8, 1, 1);      // R7 self loop
    run_cmd(0, 1);
    wr16(m_avail + 2, 5); wr16(m_avail + 12, 0);
    for (int i = 0; i < 8; i++) put_desc(i, 64'h7000 + i, 16 + i, (i == 7) ? 2 : (i % 2 == 0 ? 1 : 3), i + 1);
    run_cmd(0, 1);                       // R7 exact length, no abort
    wr16(m_avail + 2, 10);
    run_cmd(1, 0); run_cmd(1, 0); run_cmd(1, 0);
    wr16(m_avail + 4, 3);                // R4 slot 0 reused at index 8
    run_cmd(0, 1);
    load_pfn(64'h12345);                 // R1 large page, R2 index cleared
    load_pfn(0);                         // R2 clear
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule